// File: doc/BRIEF.md
# Power-Up Strap Sampling Controller

This block sequences a small group of shared pads that serve first as configuration straps and afterwards as clock outputs. When the supply-good indication rises, it keeps every pad driver off (high impedance) for a fixed number of reference-clock cycles. During this time the external pull resistors settle each pad to its strap level. On the last cycle of that wait, the block captures all pad levels. One cycle later it turns the drivers on and raises a completion flag.

Four pads are handled. Pad 0 carries the mode strap. A captured 1 makes the shared pad a reference-clock output, and a captured 0 makes it the PCI clock-stop input. Pads 1, 2 and 3 carry the frequency-select bits 0, 1 and 2. The captured three-bit code is decoded into three outputs: the CPU clock rate in tenths of a MHz, the PCI divider choice, and a reserved-code flag.

The captured values stay frozen until supply-good falls. That fall is the only way to clear them, because it models a power cycle. Detecting the supply voltage itself happens outside the block.

Top module: `strap_power_seq`

## Requirements
- R1: While `pwr_good` is low, `pad_oe` is 0000, `seq_done` is 0, `strap_mode`, `strap_fs` and `cpu_rate` are 0, and `pci_div3` and `fs_reserved` are 0.
- R2: After `pwr_good` rises, `pad_oe` stays 0000 through the first WINDOW_CYCLES+1 rising clock edges. After edge WINDOW_CYCLES+1, all four bits are 1.
- R3: At rising edge number WINDOW_CYCLES the pad levels are captured: `strap_mode` = `pad_in[0]` and `strap_fs` = {`pad_in[3]`,`pad_in[2]`,`pad_in[1]`}. They are visible one cycle before `pad_oe` turns on. A pad level that changes before that edge is taken at its value on that edge.
- R4: Once captured, `strap_mode`, `strap_fs` and the decoded outputs do not follow later changes on `pad_in`.
- R5: `seq_done` rises in the same cycle that `pad_oe` turns on and stays at 1 while `pwr_good` stays high.
- R6: A fall of `pwr_good` clears every output. The next rise captures fresh pad levels.
- R7: If `pwr_good` falls in the middle of the wait, the next rise starts a full new wait of WINDOW_CYCLES edges.
- R8: `cpu_rate` (tenths of a MHz) follows the captured code `strap_fs`: 111 and 101 give 1000, 100 gives 1030, 011 and 001 give 668, 010 gives 833, 000 gives 1240, and 110 gives 0.
- R9: `pci_div3` is 1 for codes 111, 101, 100 and 000 (PCI at CPU/3). It is 0 for 011, 010 and 001 (CPU/2) and for 110.
- R10: `fs_reserved` is 1 only for captured code 110 and only after capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock that times the wait |
| pwr_good | input | 1 | Supply-good; low acts as power-off reset |
| pad_in | input | 4 | Pad levels: [0] mode, [1] FS0, [2] FS1, [3] FS2 |
| pad_oe | output | 4 | Per-pad driver enable; 0 = high impedance |
| seq_done | output | 1 | Sequence complete, drivers on |
| strap_mode | output | 1 | Captured mode: 1 reference out, 0 stop input |
| strap_fs | output | 3 | Captured frequency code {FS2,FS1,FS0} |
| cpu_rate | output | 11 | Decoded CPU rate in tenths of a MHz |
| pci_div3 | output | 1 | PCI clock is CPU/3 when 1, CPU/2 when 0 |
| fs_reserved | output | 1 | Captured code is the reserved value |

## Verification
The bench counts edges from the rise of `pwr_good`. A design that is off by one would turn drivers on a cycle early or late, or would capture before the pads settle. It changes pad levels one cycle before the capture edge and right after it. A design that samples too early or keeps sampling would show the wrong strap. It aborts a wait halfway through. A design that does not restart its counter would enable drivers too soon on the next rise. It walks all eight frequency codes through full power cycles, which exposes swapped code bits or a missing reserved case.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    localparam int STRAP_PADS = 4;
    localparam int FS_W       = 3;
    localparam int RATE_W     = 11;

    localparam logic [RATE_W-1:0] RATE_100_0 = RATE_W'(1000);
    localparam logic [RATE_W-1:0] RATE_103_0 = RATE_W'(1030);
    localparam logic [RATE_W-1:0] RATE_66_8  = RATE_W'(668);
    localparam logic [RATE_W-1:0] RATE_83_3  = RATE_W'(833);
    localparam logic [RATE_W-1:0] RATE_124_0 = RATE_W'(1240);

    typedef enum logic [1:0] {
        SEQ_WAIT  = 2'd0,
        SEQ_LATCH = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic            valid;
        logic            mode;
        logic [FS_W-1:0] fs;
    } strap_word_t;

endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && (tmr_q.cnt == LAST);
        if (run && !expire) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [STRAP_PADS-1:0] pad_lvl,
    output strap_word_t           word
);
    strap_word_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture && !cap_q.valid) begin
            cap_d.valid = 1'b1;
            cap_d.mode  = pad_lvl[0];
            cap_d.fs    = pad_lvl[STRAP_PADS-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word = cap_q;
endmodule

// File: rtl/strap_freq_decode.sv
module strap_freq_decode
    import strap_seq_pkg::*;
(
    input  logic              valid,
    input  logic [FS_W-1:0]   fs,
    output logic [RATE_W-1:0] rate,
    output logic              div3,
    output logic              reserved
);
    always_comb begin
        rate     = '0;
        div3     = 1'b0;
        reserved = 1'b0;
        if (valid) begin
            unique case (fs)
                3'b111, 3'b101: begin rate = RATE_100_0; div3 = 1'b1; end
                3'b100:         begin rate = RATE_103_0; div3 = 1'b1; end
                3'b000:         begin rate = RATE_124_0; div3 = 1'b1; end
                3'b011, 3'b001: begin rate = RATE_66_8;  div3 = 1'b0; end
                3'b010:         begin rate = RATE_83_3;  div3 = 1'b0; end
                default:        begin reserved = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/strap_power_seq.sv
module strap_power_seq
    import strap_seq_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic                  clk_ref,
    input  logic                  pwr_good,
    input  logic [STRAP_PADS-1:0] pad_in,
    output logic [STRAP_PADS-1:0] pad_oe,
    output logic                  seq_done,
    output logic                  strap_mode,
    output logic [FS_W-1:0]       strap_fs,
    output logic [RATE_W-1:0]     cpu_rate,
    output logic                  pci_div3,
    output logic                  fs_reserved
);
    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t        seq_d, seq_q;
    logic        win_expire;
    logic        drv_on;
    strap_word_t cap_word;

    strap_window_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) i_timer (
        .clk    (clk_ref),
        .rst_n  (pwr_good),
        .run    (seq_q.state == SEQ_WAIT),
        .expire (win_expire)
    );

    strap_capture i_capture (
        .clk     (clk_ref),
        .rst_n   (pwr_good),
        .capture (win_expire),
        .pad_lvl (pad_in),
        .word    (cap_word)
    );

    strap_freq_decode i_decode (
        .valid    (cap_word.valid),
        .fs       (cap_word.fs),
        .rate     (cpu_rate),
        .div3     (pci_div3),
        .reserved (fs_reserved)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_WAIT:  if (win_expire) seq_d.state = SEQ_LATCH;
            SEQ_LATCH: seq_d.state = SEQ_RUN;
            default:   seq_d.state = SEQ_RUN;
        endcase
    end

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good) begin
            seq_q <= '{state: SEQ_WAIT};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign drv_on = (seq_q.state == SEQ_RUN);

    for (genvar p = 0; p < STRAP_PADS; p++) begin : g_pad_oe
        assign pad_oe[p] = drv_on;
    end

    assign seq_done   = drv_on;
    assign strap_mode = cap_word.mode;
    assign strap_fs   = cap_word.fs;
endmodule

// File: rtl/strap_power_seq_chk.sv
module strap_power_seq_chk
    import strap_seq_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input logic                  clk_ref,
    input logic                  pwr_good,
    input logic [STRAP_PADS-1:0] pad_oe,
    input logic                  seq_done,
    input logic                  strap_mode,
    input logic [FS_W-1:0]       strap_fs,
    input logic [RATE_W-1:0]     cpu_rate,
    input logic                  fs_reserved
);
    logic [31:0] since_q;

    always_ff @(posedge clk_ref or negedge pwr_good) begin
        if (!pwr_good) begin
            since_q <= '0;
        end else if (since_q != 32'hFFFF_FFFF) begin
            since_q <= since_q + 32'd1;
        end
    end

    // R2
    window_closed_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (since_q <= 32'(WINDOW_CYCLES)) |-> (pad_oe == '0));

    // R2
    drivers_on_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        (since_q == 32'(WINDOW_CYCLES + 1)) |-> (pad_oe == '1));

    // R5
    done_with_oe_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        seq_done |-> (pad_oe == '1));

    // R5
    done_sticky_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        seq_done |=> seq_done);

    // R3
    captured_before_oe_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        $rose(seq_done) |-> ($stable(strap_fs) && $stable(strap_mode)));

    // R4
    frozen_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        seq_done |=> ($stable(strap_fs) && $stable(strap_mode) && $stable(cpu_rate)));

    // R10
    reserved_rate_chk: assert property (@(posedge clk_ref) disable iff (!pwr_good)
        fs_reserved |-> (cpu_rate == '0 && strap_fs == 3'b110));
endmodule

bind strap_power_seq strap_power_seq_chk #(
    .WINDOW_CYCLES(WINDOW_CYCLES)
) i_chk (
    .clk_ref     (clk_ref),
    .pwr_good    (pwr_good),
    .pad_oe      (pad_oe),
    .seq_done    (seq_done),
    .strap_mode  (strap_mode),
    .strap_fs    (strap_fs),
    .cpu_rate    (cpu_rate),
    .fs_reserved (fs_reserved)
);

// File: tb/test_strap_power_seq.sv
`timescale 1ns/1ps
module test_strap_power_seq;
    localparam int W = 40;

    logic        clk_ref = 1'b0;
    logic        pwr_good = 1'b0;
    logic [3:0]  pad_in = 4'b0000;
    logic [3:0]  pad_oe;
    logic        seq_done;
    logic        strap_mode;
    logic [2:0]  strap_fs;
    logic [10:0] cpu_rate;
    logic        pci_div3;
    logic        fs_reserved;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk_ref = ~clk_ref;

    strap_power_seq #(.WINDOW_CYCLES(W)) i_strap_power_seq (
        .clk_ref(clk_ref), .pwr_good(pwr_good), .pad_in(pad_in),
        .pad_oe(pad_oe), .seq_done(seq_done), .strap_mode(strap_mode),
        .strap_fs(strap_fs), .cpu_rate(cpu_rate), .pci_div3(pci_div3),
        .fs_reserved(fs_reserved)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_rate(input logic [2:0] c);
        case (c)
            3'b111, 3'b101: return 1000;
            3'b100:         return 1030;
            3'b011, 3'b001: return 668;
            3'b010:         return 833;
            3'b000:         return 1240;
            default:        return 0;
        endcase
    endfunction

    function automatic bit exp_div3(input logic [2:0] c);
        return (c == 3'b111 || c == 3'b101 || c == 3'b100 || c == 3'b000);
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk_ref);
        #1;
    endtask

    task automatic power_off();
        @(negedge clk_ref);
        pwr_good = 1'b0;
        #1;
    endtask

    task automatic power_on(input logic [3:0] pads);
        @(negedge clk_ref);
        pad_in   = pads;
        pwr_good = 1'b1;
    endtask

    task automatic t_reset();
        power_off();
        edges(3);
        chk(pad_oe == 4'b0000, "R1 pad_oe", pad_oe, 0);
        chk(seq_done == 1'b0, "R1 seq_done", seq_done, 0);
        chk(strap_fs == 3'b000 && strap_mode == 1'b0, "R1 straps", {strap_fs, strap_mode}, 0);
        chk(cpu_rate == 0 && !pci_div3 && !fs_reserved, "R1 decode", cpu_rate, 0);
    endtask

    task automatic t_window();
        bit early_on = 0;
        power_off();
        power_on(4'b1011);
        for (int k = 1; k < W; k++) begin
            edges(1);
            if (pad_oe != 4'b0000) early_on = 1;
        end
        chk(!early_on, "R2 hiz during window", early_on, 0);
        chk(strap_fs == 3'b000, "R3 not yet captured", strap_fs, 0);
        edges(1);
        chk(strap_mode == 1'b1, "R3 mode captured", strap_mode, 1);
        chk(strap_fs == 3'b101, "R3 fs captured", strap_fs, 5);
        chk(pad_oe == 4'b0000, "R2 oe still off at capture", pad_oe, 0);
        chk(seq_done == 1'b0, "R5 done off at capture", seq_done, 0);
        edges(1);
        chk(pad_oe == 4'b1111, "R2 oe on", pad_oe, 15);
        chk(seq_done == 1'b1, "R5 done on", seq_done, 1);
        chk(cpu_rate == 1000 && pci_div3, "R8 rate 101", cpu_rate, 1000);
    endtask

    task automatic t_frozen();
        @(negedge clk_ref);
        pad_in = 4'b0100;
        edges(10);
        chk(strap_fs == 3'b101 && strap_mode == 1'b1, "R4 straps frozen", strap_fs, 5);
        chk(cpu_rate == 1000, "R4 rate frozen", cpu_rate, 1000);
        chk(seq_done == 1'b1 && pad_oe == 4'b1111, "R5 done held", seq_done, 1);
    endtask

    task automatic t_late_change();
        power_off();
        power_on(4'b0000);
        edges(W - 1);
        @(negedge clk_ref);
        pad_in = 4'b0111;
        edges(1);
        chk(strap_fs == 3'b011 && strap_mode == 1'b1, "R3 last-cycle level", {strap_fs, strap_mode}, 7);
        @(negedge clk_ref);
        pad_in = 4'b1000;
        edges(3);
        chk(strap_fs == 3'b011, "R4 change after capture ignored", strap_fs, 3);
        chk(cpu_rate == 668 && !pci_div3, "R9 div2 for 011", cpu_rate, 668);
    endtask

    task automatic t_recycle();
        power_off();
        chk(strap_fs == 3'b000 && seq_done == 1'b0, "R6 cleared on power drop", strap_fs, 0);
        power_on(4'b0100);
        edges(W + 1);
        chk(strap_fs == 3'b010 && strap_mode == 1'b0, "R6 fresh capture", {strap_fs, strap_mode}, 4);
        chk(cpu_rate == 833 && !pci_div3, "R8 rate 010", cpu_rate, 833);
    endtask

    task automatic t_abort();
        bit early_on = 0;
        power_off();
        power_on(4'b0001);
        edges(W / 2);
        power_off();
        chk(pad_oe == 4'b0000 && strap_fs == 3'b000, "R7 abort clears", pad_oe, 0);
        power_on(4'b1001);
        for (int k = 1; k <= W; k++) begin
            edges(1);
            if (pad_oe != 4'b0000) early_on = 1;
        end
        chk(!early_on, "R7 full window after abort", early_on, 0);
        edges(1);
        chk(pad_oe == 4'b1111 && strap_fs == 3'b100, "R7 completes after restart", strap_fs, 4);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            logic [2:0] code = 3'(c);
            power_off();
            power_on({code, 1'b0});
            edges(W + 1);
            chk(strap_fs == code, "R3 code captured", strap_fs, c);
            chk(int'(cpu_rate) == exp_rate(code), "R8 rate", cpu_rate, exp_rate(code));
            chk(pci_div3 == exp_div3(code), "R9 pci divider", pci_div3, exp_div3(code));
            chk(fs_reserved == (code == 3'b110), "R10 reserved flag", fs_reserved, (code == 3'b110));
        end
    endtask

    initial begin
        t_reset();
        t_window();
        t_frozen();
        t_late_change();
        t_recycle();
        t_abort();
        t_codes();
        t_reset();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_ref);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule